// File: doc/BRIEF.md
# Serial NOR Flash Command Responder

This block behaves like a serial NOR flash device seen at byte level. A host frames each transaction with a one-cycle frame-open strobe and a one-cycle frame-close strobe. Between them it supplies opcode, address and program bytes on a valid-qualified byte input. It asks for read-phase bytes with a read request strobe. The block decodes the opcode, collects the address and then acts on a small internal byte array. It can program bytes, erase regions of several sizes, erase the whole array, stream bytes out, report its identity and report its status register.

The status register holds a busy (write-in-progress) flag and a write-enable latch. Modifying commands run only while the latch is set, and each one that completes sets busy and drops the latch. Busy clears on the first status read after it was set. This stands in for the real program and erase time. Address length is three bytes after reset and can be switched to four bytes and back by command. Malformed traffic produces a one-cycle protocol error pulse. Accesses beyond the array produce a one-cycle range error pulse.

Top module: `nor_cmd_responder`

## Requirements
- R1: After reset every array byte reads 0xFF, the status register reads 0x00 and the address length is three bytes.
- R2: Opcode 0x9F followed by read requests returns 0x55, 0xAA, 0x55 and then 0x00 for every further request.
- R3: Opcode 0x05 returns the status register on each read request, with bit 0 as busy and bit 1 as write-enable latch and all other bits zero. Busy is cleared after each such byte is returned, so a second request in the same frame shows busy as 0.
- R4: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it.
- R5: Opcode 0x03 collects the address most significant byte first. Each later read request returns the byte at the current address and then increments the address linearly. out_valid and out_byte appear one clock after the request is sampled.
- R6: Opcode 0xB7 selects four-byte addresses and opcode 0xE9 returns to three-byte addresses. Read, program and erase all use the selected length.
- R7: Opcode 0x02, after its address, ANDs each data byte into the addressed array byte, so bits can only change from 1 to 0.
- R8: During programming only the low 8 address bits increment after each data byte, so the address wraps inside its 256-byte page.
- R9: A frame close that follows at least one program data byte sets busy and clears the write-enable latch.
- R10: Program (0x02), region erases (0x20, 0x52, 0xD8) and chip erase (0x60) issued while the write-enable latch is clear leave the array and the status register unchanged, and raise no error.
- R11: When the last address byte of 0x20, 0x52 or 0xD8 arrives, the bytes from that address up to 4096, 32768 or 65536 bytes later, clipped to the array end, become 0xFF. Busy is then set and the latch is cleared.
- R12: Opcode 0x60 with the latch set makes the whole array 0xFF at once, sets busy and clears the latch.
- R13: A read request or a program data byte at an address at or above the array size pulses range_err one clock later. That program byte is dropped and that read returns 0x00.
- R14: err_pulse goes high for one clock after any of these: an unsupported opcode, a byte or read request in a phase that cannot take it, or in_valid and rd_req together. After an error the rest of the frame is ignored. Frame close returns the decoder to idle. Inputs in the same cycle as a frame strobe are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe opening a transaction |
| frame_end | input | 1 | One-cycle strobe closing a transaction |
| in_valid | input | 1 | in_byte carries an opcode, address or data byte |
| in_byte | input | 8 | Host-to-device byte |
| rd_req | input | 1 | Request one byte in a read phase |
| out_byte | output | 8 | Device-to-host byte |
| out_valid | output | 1 | out_byte is valid this cycle |
| err_pulse | output | 1 | Protocol error pulse |
| range_err | output | 1 | Access beyond array end pulse |

## Verification
out_byte, out_valid, err_pulse and range_err are each registered once, so they are due in the clock after the edge that samples the request or byte. The bench drives inputs on a falling edge and reads these outputs on the next falling edge, just after the registering edge. Array and status changes take effect at the edge that samples the byte or the frame close. The bench observes them only through later frames, with status reads and array reads, and compares the results with its own array and status model.

// File: rtl/nor_pkg.sv
// Package: opcode values, erase region sizes, identity bytes and the
// decoder state encoding shared by the flash responder modules.
package nor_pkg;

    localparam logic [7:0] OP_PROG    = 8'h02;
    localparam logic [7:0] OP_READ    = 8'h03;
    localparam logic [7:0] OP_WR_DIS  = 8'h04;
    localparam logic [7:0] OP_STATUS  = 8'h05;
    localparam logic [7:0] OP_WR_EN   = 8'h06;
    localparam logic [7:0] OP_ER_4K   = 8'h20;
    localparam logic [7:0] OP_ER_32K  = 8'h52;
    localparam logic [7:0] OP_ER_ALL  = 8'h60;
    localparam logic [7:0] OP_IDENT   = 8'h9F;
    localparam logic [7:0] OP_ADDR4   = 8'hB7;
    localparam logic [7:0] OP_ER_64K  = 8'hD8;
    localparam logic [7:0] OP_ADDR3   = 8'hE9;

    localparam logic [31:0] LEN_4K  = 32'h0000_1000;
    localparam logic [31:0] LEN_32K = 32'h0000_8000;
    localparam logic [31:0] LEN_64K = 32'h0001_0000;

    localparam logic [7:0] ID_B0 = 8'h55;
    localparam logic [7:0] ID_B1 = 8'hAA;
    localparam logic [7:0] ID_B2 = 8'h55;

    typedef enum logic [3:0] {
        ST_IDLE,    // outside any frame
        ST_OPC,     // waiting for opcode
        ST_IDENT,   // identity read phase
        ST_STAT,    // status read phase
        ST_RADDR,   // collecting read address
        ST_RDATA,   // streaming read data
        ST_PADDR,   // collecting program address
        ST_PDATA,   // accepting program data
        ST_EADDR,   // collecting erase address
        ST_DONE,    // command complete, no more bytes allowed
        ST_QUIET,   // command refused for lack of write enable; silent
        ST_SKIP     // error seen; rest of frame ignored
    } dec_state_t;

endpackage

// File: rtl/nor_status.sv
// Module: nor_status
// Holds the busy flag, the write-enable latch and the address-length mode.
// Assumes the decoder never raises a set and a clear of the same bit in one
// cycle except completion (set busy with clear latch), where set wins for busy.
module nor_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_wip,
    input  logic clr_wip,
    input  logic set_wel,
    input  logic clr_wel,
    input  logic set_4b,
    input  logic clr_4b,
    output logic wip,
    output logic wel,
    output logic four_b
);

    // Status bit update with fixed priorities.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wip    <= 1'b0;
            wel    <= 1'b0;
            four_b <= 1'b0;
        end else begin
            if (set_wip)      wip <= 1'b1;
            else if (clr_wip) wip <= 1'b0;
            if (clr_wel)      wel <= 1'b0;
            else if (set_wel) wel <= 1'b1;
            if (set_4b)       four_b <= 1'b1;
            else if (clr_4b)  four_b <= 1'b0;
        end
    end

    // R4: the latch only rises after a write-enable command.
    p_wel_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(set_wel));

    // R9: busy only rises after a completion event.
    p_wip_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(set_wip));

endmodule

// File: rtl/nor_array.sv
// Module: nor_array
// Byte array with AND-programming of one byte, region fill with 0xFF and
// whole-array fill. Assumes MEM_BYTES is a power of two of at least 256.
module nor_array #(
    parameter int MEM_BYTES = 2048,
    parameter int AW        = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_we,
    input  logic [AW-1:0] prog_idx,
    input  logic [7:0]    prog_data,
    input  logic          erase_go,
    input  logic [31:0]   erase_base,
    input  logic [31:0]   erase_len,
    input  logic          chip_erase,
    input  logic [AW-1:0] rd_idx,
    output logic [7:0]    rd_data
);

    logic [7:0]           mem [MEM_BYTES];
    logic [MEM_BYTES-1:0] fill;
    logic [32:0]          er_lo;
    logic [32:0]          er_hi;

    // Erase window bounds, widened to avoid overflow at the top.
    always_comb begin
        er_lo = {1'b0, erase_base};
        er_hi = {1'b0, erase_base} + {1'b0, erase_len};
    end

    // One fill decision per entry.
    for (genvar i = 0; i < MEM_BYTES; i++) begin : g_fill
        localparam logic [32:0] IDX = 33'(i);
        assign fill[i] = chip_erase | (erase_go & (IDX >= er_lo) & (IDX < er_hi));
    end

    // Array update: fill beats program; reset leaves all bytes erased.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < MEM_BYTES; k++) mem[k] <= 8'hFF;
        end else begin
            for (int k = 0; k < MEM_BYTES; k++) begin
                if (fill[k])
                    mem[k] <= 8'hFF;
                else if (prog_we && (prog_idx == AW'(k)))
                    mem[k] <= mem[k] & prog_data;
            end
        end
    end

    // Read port, combinational.
    assign rd_data = mem[rd_idx];

    // R7: a programmed byte never gains a set bit.
    p_and_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_we && !erase_go && !chip_erase) |=>
        ((mem[$past(prog_idx)] & ~$past(rd_data_at_prog)) == 8'h00));

    logic [7:0] rd_data_at_prog;
    assign rd_data_at_prog = mem[prog_idx];

endmodule

// File: rtl/nor_decoder.sv
// Module: nor_decoder
// Frame-level command decoder: opcode decode, address collection, program,
// erase and read phases, output byte and error pulses. Assumes frame_end
// outranks frame_start, which outranks byte and read request inputs.
module nor_decoder
    import nor_pkg::*;
#(
    parameter int MEM_BYTES = 2048,
    parameter int AW        = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          frame_end,
    input  logic          in_valid,
    input  logic [7:0]    in_byte,
    input  logic          rd_req,
    input  logic          wip,
    input  logic          wel,
    input  logic          four_b,
    input  logic [7:0]    mem_rd_data,
    output logic [AW-1:0] mem_rd_idx,
    output logic          prog_we,
    output logic [AW-1:0] prog_idx,
    output logic [7:0]    prog_data,
    output logic          erase_go,
    output logic [31:0]   erase_base,
    output logic [31:0]   erase_len,
    output logic          chip_erase,
    output logic          set_wip,
    output logic          clr_wip,
    output logic          set_wel,
    output logic          clr_wel,
    output logic          set_4b,
    output logic          clr_4b,
    output logic [7:0]    out_byte,
    output logic          out_valid,
    output logic          err_pulse,
    output logic          range_err
);

    localparam logic [31:0] MEM_LIM = 32'(MEM_BYTES);

    dec_state_t  st;
    logic [31:0] addr;
    logic [1:0]  cnt;
    logic [1:0]  id_idx;
    logic        four_lat;
    logic        prog_seen;
    logic [31:0] len_lat;

    logic bus_free, accept, rdq, clash, opc_hit, addr_last, in_range, prog_end;
    logic clr_wel_cmd;

    // Input qualification by priority.
    always_comb begin
        bus_free  = !frame_start && !frame_end;
        accept    = bus_free && in_valid && !rd_req;
        rdq       = bus_free && rd_req && !in_valid;
        clash     = bus_free && rd_req && in_valid;
        opc_hit   = accept && (st == ST_OPC);
        addr_last = accept && (cnt == (four_lat ? 2'd3 : 2'd2));
        in_range  = addr < MEM_LIM;
    end

    // Strobes to the status register and the array.
    always_comb begin
        set_wel     = opc_hit && (in_byte == OP_WR_EN);
        clr_wel_cmd = opc_hit && (in_byte == OP_WR_DIS);
        set_4b      = opc_hit && (in_byte == OP_ADDR4);
        clr_4b      = opc_hit && (in_byte == OP_ADDR3);
        chip_erase  = opc_hit && (in_byte == OP_ER_ALL) && wel;
        erase_go    = (st == ST_EADDR) && addr_last;
        erase_base  = {addr[23:0], in_byte};
        erase_len   = len_lat;
        prog_we     = (st == ST_PDATA) && accept && in_range;
        prog_idx    = addr[AW-1:0];
        prog_data   = in_byte;
        prog_end    = frame_end && (st == ST_PDATA) && prog_seen;
        set_wip     = chip_erase || erase_go || prog_end;
        clr_wel     = clr_wel_cmd || set_wip;
        clr_wip     = rdq && (st == ST_STAT);
        mem_rd_idx  = addr[AW-1:0];
    end

    // Frame state machine, address register and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            addr      <= '0;
            cnt       <= '0;
            id_idx    <= '0;
            four_lat  <= 1'b0;
            prog_seen <= 1'b0;
            len_lat   <= LEN_4K;
            out_byte  <= '0;
            out_valid <= 1'b0;
            err_pulse <= 1'b0;
            range_err <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            err_pulse <= 1'b0;
            range_err <= 1'b0;
            if (frame_end) begin
                st        <= ST_IDLE;
                prog_seen <= 1'b0;
            end else if (frame_start) begin
                st        <= ST_OPC;
                addr      <= '0;
                cnt       <= '0;
                id_idx    <= '0;
                prog_seen <= 1'b0;
            end else if (clash) begin
                err_pulse <= 1'b1;
                if (st != ST_IDLE) st <= ST_SKIP;
            end else if (accept) begin
                case (st)
                    ST_OPC: begin
                        four_lat <= four_b;
                        case (in_byte)
                            OP_IDENT:  st <= ST_IDENT;
                            OP_STATUS: st <= ST_STAT;
                            OP_READ:   st <= ST_RADDR;
                            OP_PROG:   st <= wel ? ST_PADDR : ST_QUIET;
                            OP_ER_4K: begin
                                st      <= wel ? ST_EADDR : ST_QUIET;
                                len_lat <= LEN_4K;
                            end
                            OP_ER_32K: begin
                                st      <= wel ? ST_EADDR : ST_QUIET;
                                len_lat <= LEN_32K;
                            end
                            OP_ER_64K: begin
                                st      <= wel ? ST_EADDR : ST_QUIET;
                                len_lat <= LEN_64K;
                            end
                            OP_ER_ALL, OP_WR_EN, OP_WR_DIS, OP_ADDR4, OP_ADDR3:
                                st <= ST_DONE;
                            default: begin
                                err_pulse <= 1'b1;
                                st        <= ST_SKIP;
                            end
                        endcase
                    end
                    ST_RADDR, ST_PADDR, ST_EADDR: begin
                        addr <= {addr[23:0], in_byte};
                        cnt  <= cnt + 2'd1;
                        if (addr_last) begin
                            if (st == ST_RADDR)      st <= ST_RDATA;
                            else if (st == ST_PADDR) st <= ST_PDATA;
                            else                     st <= ST_DONE;
                        end
                    end
                    ST_PDATA: begin
                        prog_seen <= 1'b1;
                        if (!in_range) range_err <= 1'b1;
                        addr <= {addr[31:8], addr[7:0] + 8'd1};
                    end
                    ST_QUIET, ST_SKIP: ;
                    default: begin
                        err_pulse <= 1'b1;
                        if (st != ST_IDLE) st <= ST_SKIP;
                    end
                endcase
            end else if (rdq) begin
                case (st)
                    ST_IDENT: begin
                        out_valid <= 1'b1;
                        case (id_idx)
                            2'd0:    out_byte <= ID_B0;
                            2'd1:    out_byte <= ID_B1;
                            2'd2:    out_byte <= ID_B2;
                            default: out_byte <= 8'h00;
                        endcase
                        if (id_idx != 2'd3) id_idx <= id_idx + 2'd1;
                    end
                    ST_STAT: begin
                        out_valid <= 1'b1;
                        out_byte  <= {6'b0, wel, wip};
                    end
                    ST_RDATA: begin
                        out_valid <= 1'b1;
                        if (in_range) begin
                            out_byte <= mem_rd_data;
                        end else begin
                            out_byte  <= 8'h00;
                            range_err <= 1'b1;
                        end
                        addr <= addr + 32'd1;
                    end
                    ST_QUIET, ST_SKIP: ;
                    default: begin
                        err_pulse <= 1'b1;
                        if (st != ST_IDLE) st <= ST_SKIP;
                    end
                endcase
            end
        end
    end

    // R14: an error pulse always follows a byte or read request.
    p_err_cause_r14: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(in_valid || rd_req));

    // R5: output bytes only appear one clock after a read request.
    p_out_after_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(rd_req));

    // R10: no array write unless the status latch is set.
    p_prog_needs_wel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |-> wel);

    // R11: no erase unless the status latch is set.
    p_erase_needs_wel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_go || chip_erase) |-> wel);

    // R8: program data never moves the address outside its page.
    p_page_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PDATA && accept) |=> $stable(addr[31:8]));

endmodule

// File: rtl/nor_cmd_responder.sv
// Module: nor_cmd_responder
// Top level of the byte-level serial NOR flash responder: wires the frame
// decoder to the status register and the byte array. Assumes the host sends
// one-cycle frame strobes and never overlaps two frames.
module nor_cmd_responder #(
    parameter int MEM_BYTES = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       frame_end,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       rd_req,
    output logic [7:0] out_byte,
    output logic       out_valid,
    output logic       err_pulse,
    output logic       range_err
);

    localparam int AW = $clog2(MEM_BYTES);

    logic          wip, wel, four_b;
    logic          set_wip, clr_wip, set_wel, clr_wel, set_4b, clr_4b;
    logic          prog_we, erase_go, chip_erase;
    logic [AW-1:0] prog_idx, rd_idx;
    logic [7:0]    prog_data, rd_data;
    logic [31:0]   erase_base, erase_len;

    nor_decoder #(.MEM_BYTES(MEM_BYTES), .AW(AW)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .frame_start(frame_start), .frame_end(frame_end),
        .in_valid(in_valid), .in_byte(in_byte), .rd_req(rd_req),
        .wip(wip), .wel(wel), .four_b(four_b),
        .mem_rd_data(rd_data), .mem_rd_idx(rd_idx),
        .prog_we(prog_we), .prog_idx(prog_idx), .prog_data(prog_data),
        .erase_go(erase_go), .erase_base(erase_base), .erase_len(erase_len),
        .chip_erase(chip_erase),
        .set_wip(set_wip), .clr_wip(clr_wip),
        .set_wel(set_wel), .clr_wel(clr_wel),
        .set_4b(set_4b), .clr_4b(clr_4b),
        .out_byte(out_byte), .out_valid(out_valid),
        .err_pulse(err_pulse), .range_err(range_err)
    );

    nor_status u_stat (
        .clk(clk), .rst_n(rst_n),
        .set_wip(set_wip), .clr_wip(clr_wip),
        .set_wel(set_wel), .clr_wel(clr_wel),
        .set_4b(set_4b), .clr_4b(clr_4b),
        .wip(wip), .wel(wel), .four_b(four_b)
    );

    nor_array #(.MEM_BYTES(MEM_BYTES), .AW(AW)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .prog_we(prog_we), .prog_idx(prog_idx), .prog_data(prog_data),
        .erase_go(erase_go), .erase_base(erase_base), .erase_len(erase_len),
        .chip_erase(chip_erase),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

endmodule

// File: tb/tb_nor_cmd_responder.sv
module tb_nor_cmd_responder;

    localparam int MEMB = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       frame_end = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       rd_req = 1'b0;
    logic [7:0] out_byte;
    logic       out_valid;
    logic       err_pulse;
    logic       range_err;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    logic [7:0] mdl [MEMB];
    logic       m_wip, m_wel, m_4b;

    always #10 clk = ~clk;

    nor_cmd_responder #(.MEM_BYTES(MEMB)) dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
        .in_valid(in_valid), .in_byte(in_byte), .rd_req(rd_req),
        .out_byte(out_byte), .out_valid(out_valid),
        .err_pulse(err_pulse), .range_err(range_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic fs();
        frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic fe();
        frame_end = 1'b1; @(negedge clk); frame_end = 1'b0;
    endtask

    task automatic sb(input logic [7:0] b, output logic e, output logic r);
        in_valid = 1'b1; in_byte = b; @(negedge clk);
        e = err_pulse; r = range_err; in_valid = 1'b0;
    endtask

    task automatic rb(output logic [7:0] b, output logic v, output logic e, output logic r);
        rd_req = 1'b1; @(negedge clk);
        b = out_byte; v = out_valid; e = err_pulse; r = range_err; rd_req = 1'b0;
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic e, r;
        fs(); sb(op, e, r); fe();
        if (op == 8'h06) m_wel = 1'b1;
        if (op == 8'h04) m_wel = 1'b0;
        if (op == 8'hB7) m_4b = 1'b1;
        if (op == 8'hE9) m_4b = 1'b0;
    endtask

    task automatic send_addr(input logic [31:0] a);
        logic e, r;
        if (m_4b) sb(a[31:24], e, r);
        sb(a[23:16], e, r); sb(a[15:8], e, r); sb(a[7:0], e, r);
    endtask

    function automatic logic [7:0] model_status();
        return {6'b0, m_wel, m_wip};
    endfunction

    // Status read: first byte against model, model then clears busy.
    task automatic status_chk(input string tag);
        logic [7:0] b; logic v, e, r, e2, r2;
        fs(); sb(8'h05, e2, r2);
        rb(b, v, e, r);
        chk(tag, {23'b0, v, b}, {23'b0, 1'b1, model_status()});
        m_wip = 1'b0;
        fe();
    endtask

    task automatic read_chk(input string tag, input logic [31:0] a, input int n);
        logic [7:0] b; logic v, e, r;
        fs(); sb(8'h03, e, r); send_addr(a);
        for (int i = 0; i < n; i++) begin
            rb(b, v, e, r);
            chk(tag, {23'b0, v, b}, {23'b0, 1'b1, mdl[(a + 32'(i)) % MEMB]});
        end
        fe();
    endtask

    task automatic prog(input logic [31:0] a, input int n, input logic [7:0] seedb, input bit rnd);
        logic e, r; logic [31:0] p; logic [7:0] d;
        fs(); sb(8'h02, e, r);
        if (!m_wel) begin
            send_addr(a);
            for (int i = 0; i < n; i++) sb(seedb, e, r);
            fe();
            return;
        end
        send_addr(a);
        p = a;
        for (int i = 0; i < n; i++) begin
            d = rnd ? 8'($urandom) : seedb;
            sb(d, e, r);
            if (p < MEMB) mdl[p] = mdl[p] & d;
            p = {p[31:8], p[7:0] + 8'd1};
        end
        fe();
        if (n > 0) begin m_wip = 1'b1; m_wel = 1'b0; end
    endtask

    task automatic erase(input logic [7:0] op, input logic [31:0] a);
        logic e, r; int len;
        len = (op == 8'h20) ? 4096 : (op == 8'h52) ? 32768 : 65536;
        fs(); sb(op, e, r); send_addr(a); fe();
        if (m_wel) begin
            for (longint i = a; i < longint'(a) + len && i < MEMB; i++) mdl[int'(i)] = 8'hFF;
            m_wip = 1'b1; m_wel = 1'b0;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] b; logic v, e, r;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < MEMB; i++) mdl[i] = 8'hFF;
        m_wip = 1'b0; m_wel = 1'b0; m_4b = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 out_valid after reset", {31'b0, out_valid}, 0);
        status_chk("R1 status after reset");
        read_chk("R1 erased after reset", 32'h0, 4);

        // R2: identity bytes
        fs(); sb(8'h9F, e, r);
        rb(b, v, e, r); chk("R2 id0", b, 8'h55);
        rb(b, v, e, r); chk("R2 id1", b, 8'hAA);
        rb(b, v, e, r); chk("R2 id2", b, 8'h55);
        rb(b, v, e, r); chk("R2 id3", b, 8'h00);
        rb(b, v, e, r); chk("R2 id4", b, 8'h00);
        fe();

        // R4: latch set and clear
        cmd1(8'h06); status_chk("R4 latch set");
        cmd1(8'h04); status_chk("R4 latch cleared");

        // R10: refused commands
        prog(32'h10, 2, 8'h00, 0);
        read_chk("R10 program refused", 32'h10, 2);
        erase(8'h20, 32'h0);
        fs(); sb(8'h60, e, r); fe();
        status_chk("R10 status unchanged");

        // R8, R9, R3: wrapping program then status
        cmd1(8'h06);
        prog(32'h0FE, 4, 8'h00, 1);
        read_chk("R8 page wrap low", 32'h0, 2);
        read_chk("R8 page wrap high", 32'hFE, 3);
        fs(); sb(8'h05, e, r);
        rb(b, v, e, r); chk("R9 busy set latch clear", b, 8'h01);
        rb(b, v, e, r); chk("R3 busy cleared by read", b, 8'h00);
        fe();
        m_wip = 1'b0;

        // R7: AND programming
        cmd1(8'h06); prog(32'h200, 1, 8'hF0, 0); status_chk("R7 status");
        cmd1(8'h06); prog(32'h200, 1, 8'h3C, 0); status_chk("R7 status2");
        read_chk("R7 and result", 32'h200, 1);
        chk("R7 model value", mdl[32'h200], 8'h30);

        // R6: four-byte addressing
        cmd1(8'hB7);
        cmd1(8'h06); prog(32'h0000_0300, 2, 8'h5A, 0); status_chk("R6 status");
        read_chk("R6 four-byte read", 32'h0000_0300, 2);
        cmd1(8'hE9);
        read_chk("R6 back to three-byte", 32'h300, 2);

        // R11: region erase from its start address
        cmd1(8'h06); erase(8'h20, 32'h201);
        status_chk("R11 erase status");
        read_chk("R11 erase start edge", 32'h200, 2);
        read_chk("R11 below region kept", 32'h0FE, 2);

        // R13: range errors
        fs(); sb(8'h03, e, r); send_addr(32'h7FF);
        rb(b, v, e, r); chk("R13 last byte no range err", {31'b0, r}, 0);
        rb(b, v, e, r); chk("R13 read range err", {31'b0, r}, 1);
        chk("R13 read data zero", b, 8'h00);
        fe();
        cmd1(8'h06);
        fs(); sb(8'h02, e, r); send_addr(32'h800);
        sb(8'h00, e, r); chk("R13 program range err", {31'b0, r}, 1);
        fe(); m_wip = 1'b1; m_wel = 1'b0;
        status_chk("R13 status after");

        // R14: protocol errors
        fs(); sb(8'hAB, e, r); chk("R14 bad opcode err", {31'b0, e}, 1);
        sb(8'h06, e, r); chk("R14 skipped byte quiet", {31'b0, e}, 0);
        fe();
        status_chk("R14 skipped write enable had no effect");
        fs(); sb(8'h04, e, r); sb(8'h00, e, r); chk("R14 byte after done", {31'b0, e}, 1); fe();
        fs(); rb(b, v, e, r); chk("R14 read in opcode phase", {31'b0, e}, 1); fe();
        sb(8'h05, e, r); chk("R14 byte outside frame", {31'b0, e}, 1);
        fs(); sb(8'h05, e, r);
        rd_req = 1'b1; in_valid = 1'b1; in_byte = 8'h00; @(negedge clk);
        chk("R14 clash err", {31'b0, err_pulse}, 1);
        rd_req = 1'b0; in_valid = 1'b0;
        fe();
        status_chk("R14 recovers after frame close");

        // R5, R7, R11: random traffic against model
        for (int it = 0; it < 60; it++) begin
            int kind; logic [31:0] a;
            kind = int'($urandom % 4);
            a = $urandom % MEMB;
            case (kind)
                0, 1: begin cmd1(8'h06); prog(a, 1 + int'($urandom % 8), 8'h00, 1); end
                2:    read_chk("R5 random read", a, 1 + int'($urandom % 6));
                default: if ($urandom % 4 == 0) begin cmd1(8'h06); erase(8'h20, a | 32'h700); end
                         else read_chk("R5 random read2", a, 3);
            endcase
            status_chk("R9 random status");
        end
        read_chk("R5 full array", 32'h0, MEMB);

        // R12: chip erase
        cmd1(8'h06);
        fs(); sb(8'h60, e, r); fe();
        for (int i = 0; i < MEMB; i++) mdl[i] = 8'hFF;
        m_wip = 1'b1; m_wel = 1'b0;
        status_chk("R12 chip erase status");
        read_chk("R12 chip erase contents", 32'h0, MEMB);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule